// File: doc/BRIEF.md
# CDR Manual-Lock Reset Sequencer

This block steps a serial receiver's clock-data-recovery unit into manual lock mode. The CDR is first forced to track the reference clock. It is then switched to track incoming data. Around that switch, the receive PCS is held in digital reset. A single start pulse launches the whole sequence. After that, the controller drives the two lock-select lines and the digital reset by itself, and raises the ready flag only once the receiver can take data again.

Every status input is asynchronous to the controller clock. The sequencer passes each one through a synchronizer chain before using it. Minimum dwell times are given in nanoseconds and are turned into cycle counts from a clock-frequency parameter. The reference-lock status must stay high for the whole stability window before the switch to data lock; any low sample restarts the window. Each handshake with the PCS reset acknowledge is bounded by a timeout. If a timeout expires, the sequencer parks in an error state with the PCS held in reset, until a new start request arrives.

Top module: `cdr_manual_lock_seq`

## Requirements
- R1: Reset puts the controller in idle. In idle, `seq_state` is 0 and set-lock-to-reference, set-lock-to-data, digital reset, busy and error are all low. While idle, `rx_ready` follows the synchronized lock-to-data status, delayed by one register. State codes are: 0 idle, 1 reset-assert wait, 2 reference-stability wait, 3 data-lock dwell, 4 reset-release wait, 5 locked, 6 error.
- R2: A start request is accepted in idle (or error) only while the synchronized calibration-busy is low. On the edge that accepts it, set-lock-to-reference and digital reset both go high and the state becomes 1. Digital reset is never high while set-lock-to-reference is low.
- R3: In state 1, the controller waits for the synchronized reset acknowledge to be high. The edge that samples it high drops `rx_ready` and enters state 2. With two synchronizer stages, this is the third rising edge after the acknowledge input rises.
- R4: Set-lock-to-data rises only after REF_CYC consecutive high samples of the synchronized lock-to-reference in state 2, where REF_CYC is ceil(CLK_MHZ*REF_STABLE_NS/1000). Any low sample restarts the count. From a clean rise of the input, set-lock-to-data goes high on rising edge REF_CYC+2.
- R5: Once set-lock-to-data is high, lock-to-reference has no effect. Dropping it does not change the state, the lock selects or the dwell timing.
- R6: Digital reset is released exactly DWELL_CYC rising edges after set-lock-to-data rises, where DWELL_CYC is ceil(CLK_MHZ*LTD_DWELL_NS/1000). The state then becomes 4.
- R7: In state 4, `rx_ready` rises and the state becomes 5 on the edge that samples the synchronized acknowledge low and the synchronized lock-to-data high. In state 5, both lock selects stay high.
- R8: If the condition awaited in state 1 or state 4 is not met within ACK_TIMEOUT_CYC rising edges of entering that state, the state becomes 6. In state 6, error is high, digital reset is high, `rx_ready` is low, and the lock selects keep their values.
- R9: An accepted start in state 6 goes to state 1, clears error and set-lock-to-data, and keeps digital reset high.
- R10: A start request in states 1 to 5 is ignored. Busy is high exactly in states 1 to 4, and state 5 is left only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Synchronous request to begin the manual-lock sequence |
| cal_busy_in | input | 1 | Asynchronous receiver calibration-busy status |
| lock_ref_in | input | 1 | Asynchronous CDR locked-to-reference status |
| lock_data_in | input | 1 | Asynchronous CDR locked-to-data status |
| dreset_ack_in | input | 1 | Asynchronous PCS digital-reset acknowledge |
| set_lock_ref | output | 1 | Forces the CDR to track the reference clock |
| set_lock_data | output | 1 | Forces the CDR to track received data |
| rx_dreset | output | 1 | Receive PCS digital reset |
| rx_ready | output | 1 | Receiver ready for data |
| seq_busy | output | 1 | Sequence in progress (states 1 to 4) |
| seq_error | output | 1 | Handshake timeout seen |
| seq_state | output | 3 | Current state code |

## Verification
The embedded assertions check on every cycle the orderings that must never break. Digital reset never leads the reference-lock select. The data-lock select rises only after a high reference sample and before the reset release. Ready drops and rises only on the matching acknowledge level. The error state always holds the PCS in reset, and the locked state is never left. Exact latencies can only be shown by the bench scenarios: the stability window restarting after a glitch at every offset, the dwell length, the timeout edge, and the effect of calibration-busy and late start requests.

// File: rtl/cdr_seq_pkg.sv
package cdr_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_ASSERT    = 3'd1,
    ST_REF_WAIT  = 3'd2,
    ST_LTD_DWELL = 3'd3,
    ST_REL_WAIT  = 3'd4,
    ST_LOCKED    = 3'd5,
    ST_ERROR     = 3'd6
  } seq_state_e;

  // Round a duration in ns up to whole cycles of a clk_mhz clock, at least one.
  function automatic int unsigned ns_to_cycles(input int unsigned clk_mhz,
                                               input int unsigned dur_ns);
    logic [63:0] prod;
    prod = 64'(clk_mhz) * 64'(dur_ns);
    prod = (prod + 64'd999) / 64'd1000;
    if (prod == 64'd0) prod = 64'd1;
    return prod[31:0];
  endfunction

endpackage

// File: rtl/cdr_sync_bank.sv
module cdr_sync_bank #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] pipe_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe_q[0] <= '0;
          else     pipe_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe_q[s] <= '0;
          else     pipe_q[s] <= pipe_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = pipe_q[STAGES-1];

endmodule

// File: rtl/cdr_dwell_timer.sv
module cdr_dwell_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  output logic hit
);

  localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign hit = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)        cnt_q <= '0;
    else if (run && !hit)  cnt_q <= cnt_q + 1'b1;
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

endmodule

// File: rtl/cdr_seq_fsm.sv
module cdr_seq_fsm
  import cdr_seq_pkg::*;
#(
  parameter int REF_CYC   = 1500,
  parameter int DWELL_CYC = 400,
  parameter int ACK_CYC   = 2048
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_req,
  input  logic       cal_busy_s,
  input  logic       lock_ref_s,
  input  logic       lock_data_s,
  input  logic       ack_s,
  output logic       set_lock_ref,
  output logic       set_lock_data,
  output logic       rx_dreset,
  output logic       rx_ready,
  output logic       seq_busy,
  output logic       seq_error,
  output logic [2:0] seq_state
);

  seq_state_e state_q, state_d;
  logic lref_q, lref_d, ldata_q, ldata_d, dres_q, dres_d, rdy_q, rdy_d;
  logic busy_q, err_q;

  logic ref_run, dwell_run, ack_run;
  logic ref_hit, dwell_hit, ack_hit;
  logic start_ok;

  assign ref_run   = (state_q == ST_REF_WAIT) && lock_ref_s;
  assign dwell_run = (state_q == ST_LTD_DWELL);
  assign ack_run   = (state_q == ST_ASSERT) || (state_q == ST_REL_WAIT);
  assign start_ok  = start_req && !cal_busy_s;

  cdr_dwell_timer #(.LIMIT(REF_CYC)) u_ref_tmr (
    .clk(clk), .rst(rst), .clr(!ref_run), .run(ref_run), .hit(ref_hit));

  cdr_dwell_timer #(.LIMIT(DWELL_CYC)) u_dwell_tmr (
    .clk(clk), .rst(rst), .clr(!dwell_run), .run(dwell_run), .hit(dwell_hit));

  cdr_dwell_timer #(.LIMIT(ACK_CYC)) u_ack_tmr (
    .clk(clk), .rst(rst), .clr(!ack_run), .run(ack_run), .hit(ack_hit));

  always_comb begin
    state_d = state_q;
    lref_d  = lref_q;
    ldata_d = ldata_q;
    dres_d  = dres_q;
    rdy_d   = rdy_q;
    unique case (state_q)
      ST_IDLE: begin
        rdy_d = lock_data_s;
        if (start_ok) begin
          state_d = ST_ASSERT;
          lref_d  = 1'b1;
          dres_d  = 1'b1;
          ldata_d = 1'b0;
        end
      end
      ST_ASSERT: begin
        if (ack_s) begin
          rdy_d   = 1'b0;
          state_d = ST_REF_WAIT;
        end else if (ack_hit) begin
          rdy_d   = 1'b0;
          state_d = ST_ERROR;
        end
      end
      ST_REF_WAIT: begin
        if (ref_hit) begin
          ldata_d = 1'b1;
          state_d = ST_LTD_DWELL;
        end
      end
      ST_LTD_DWELL: begin
        if (dwell_hit) begin
          dres_d  = 1'b0;
          state_d = ST_REL_WAIT;
        end
      end
      ST_REL_WAIT: begin
        if (!ack_s && lock_data_s) begin
          rdy_d   = 1'b1;
          state_d = ST_LOCKED;
        end else if (ack_hit) begin
          dres_d  = 1'b1;
          rdy_d   = 1'b0;
          state_d = ST_ERROR;
        end
      end
      ST_LOCKED: begin
      end
      ST_ERROR: begin
        dres_d = 1'b1;
        rdy_d  = 1'b0;
        if (start_ok) begin
          state_d = ST_ASSERT;
          lref_d  = 1'b1;
          ldata_d = 1'b0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      lref_q  <= 1'b0;
      ldata_q <= 1'b0;
      dres_q  <= 1'b0;
      rdy_q   <= 1'b0;
      busy_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      lref_q  <= lref_d;
      ldata_q <= ldata_d;
      dres_q  <= dres_d;
      rdy_q   <= rdy_d;
      busy_q  <= (state_d == ST_ASSERT) || (state_d == ST_REF_WAIT) ||
                 (state_d == ST_LTD_DWELL) || (state_d == ST_REL_WAIT);
      err_q   <= (state_d == ST_ERROR);
    end
  end

  assign set_lock_ref  = lref_q;
  assign set_lock_data = ldata_q;
  assign rx_dreset     = dres_q;
  assign rx_ready      = rdy_q;
  assign seq_busy      = busy_q;
  assign seq_error     = err_q;
  assign seq_state     = state_q;

  // R2
  lockref_first_chk: assert property (@(posedge clk) disable iff (rst)
    dres_q |-> lref_q);

  // R3
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_REF_WAIT && $past(state_q) == ST_ASSERT) |-> (!rdy_q && $past(ack_s)));

  // R4
  ltd_after_ref_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ldata_q) |-> $past(lock_ref_s));

  // R6
  release_after_ltd_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dres_q) |-> ldata_q);

  // R7
  ready_on_ack_low_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOCKED && $past(state_q) == ST_REL_WAIT) |-> (rdy_q && !$past(ack_s)));

  // R8
  error_holds_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ERROR) |-> (dres_q && !rdy_q && err_q));

  // R10
  locked_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(state_q) == ST_LOCKED) |-> (state_q == ST_LOCKED));

endmodule

// File: rtl/cdr_manual_lock_seq.sv
module cdr_manual_lock_seq
  import cdr_seq_pkg::*;
#(
  parameter int CLK_MHZ         = 100,
  parameter int REF_STABLE_NS   = 15000,
  parameter int LTD_DWELL_NS    = 4000,
  parameter int ACK_TIMEOUT_CYC = 2048,
  parameter int SYNC_STAGES     = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_req,
  input  logic       cal_busy_in,
  input  logic       lock_ref_in,
  input  logic       lock_data_in,
  input  logic       dreset_ack_in,
  output logic       set_lock_ref,
  output logic       set_lock_data,
  output logic       rx_dreset,
  output logic       rx_ready,
  output logic       seq_busy,
  output logic       seq_error,
  output logic [2:0] seq_state
);

  localparam int REF_CYC   = int'(ns_to_cycles(CLK_MHZ, REF_STABLE_NS));
  localparam int DWELL_CYC = int'(ns_to_cycles(CLK_MHZ, LTD_DWELL_NS));
  localparam int ACK_CYC   = (ACK_TIMEOUT_CYC < 1) ? 1 : ACK_TIMEOUT_CYC;
  localparam int NSTAT     = 4;

  logic [NSTAT-1:0] stat_raw, stat_sync;

  assign stat_raw = {cal_busy_in, lock_ref_in, lock_data_in, dreset_ack_in};

  cdr_sync_bank #(.WIDTH(NSTAT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(stat_raw), .sync_out(stat_sync));

  cdr_seq_fsm #(
    .REF_CYC(REF_CYC), .DWELL_CYC(DWELL_CYC), .ACK_CYC(ACK_CYC)
  ) u_fsm (
    .clk(clk), .rst(rst), .start_req(start_req),
    .cal_busy_s(stat_sync[3]), .lock_ref_s(stat_sync[2]),
    .lock_data_s(stat_sync[1]), .ack_s(stat_sync[0]),
    .set_lock_ref(set_lock_ref), .set_lock_data(set_lock_data),
    .rx_dreset(rx_dreset), .rx_ready(rx_ready),
    .seq_busy(seq_busy), .seq_error(seq_error), .seq_state(seq_state));

endmodule

// File: tb/cdr_manual_lock_seq_bench.sv
module cdr_manual_lock_seq_bench;

  localparam int MHZ    = 1;
  localparam int REF_NS = 15000;
  localparam int DW_NS  = 6000;
  localparam int ACK_TO = 12;
  localparam int REF    = (MHZ * REF_NS + 999) / 1000;
  localparam int DWELL  = (MHZ * DW_NS + 999) / 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_req = 1'b0, cal_busy = 1'b0, lock_ref = 1'b0, lock_data = 1'b1, ack = 1'b0;
  logic set_lock_ref, set_lock_data, rx_dreset, rx_ready, seq_busy, seq_error;
  logic [2:0] seq_state;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cdr_manual_lock_seq #(
    .CLK_MHZ(MHZ), .REF_STABLE_NS(REF_NS), .LTD_DWELL_NS(DW_NS),
    .ACK_TIMEOUT_CYC(ACK_TO), .SYNC_STAGES(2)
  ) u_cdr_manual_lock_seq (
    .clk(clk), .rst(rst), .start_req(start_req), .cal_busy_in(cal_busy),
    .lock_ref_in(lock_ref), .lock_data_in(lock_data), .dreset_ack_in(ack),
    .set_lock_ref(set_lock_ref), .set_lock_data(set_lock_data),
    .rx_dreset(rx_dreset), .rx_ready(rx_ready), .seq_busy(seq_busy),
    .seq_error(seq_error), .seq_state(seq_state));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; start_req = 1'b0; ack = 1'b0; lock_ref = 1'b0;
    lock_data = 1'b1; cal_busy = 1'b0;
    step(3);
    rst = 1'b0;
    step(4);
  endtask

  task automatic pulse_start();
    start_req = 1'b1;
    step(1);
    start_req = 1'b0;
  endtask

  initial begin
    step(1);
    // R1: reset state
    check("R1 state in reset", seq_state, 0);
    check("R1 outputs in reset", {set_lock_ref, set_lock_data, rx_dreset, seq_busy, seq_error}, 0);
    do_reset();
    check("R1 idle ready follows lock_data", rx_ready, 1);
    check("R1 idle state", seq_state, 0);

    // Scenario A: complete sequence, no glitch
    pulse_start();
    check("R2 state after start", seq_state, 1);
    check("R2 lockref and dreset together", {set_lock_ref, rx_dreset}, 3);
    check("R10 busy in state 1", seq_busy, 1);
    ack = 1'b1;
    step(2);
    check("R3 ready held before ack seen", rx_ready, 1);
    step(1);
    check("R3 ready dropped", rx_ready, 0);
    check("R3 state 2", seq_state, 2);
    pulse_start();
    check("R10 start ignored in state 2", seq_state, 2);
    lock_ref = 1'b1;
    step(REF + 1);
    check("R4 lockdata not early", set_lock_data, 0);
    step(1);
    check("R4 lockdata on time", set_lock_data, 1);
    lock_ref = 1'b0;
    step(DWELL - 1);
    check("R6 dreset held in dwell", rx_dreset, 1);
    check("R5 lockref drop ignored", {set_lock_data, 5'(seq_state)}, 6'b1_00011);
    step(1);
    check("R6 dreset released", rx_dreset, 0);
    check("R6 state 4", seq_state, 4);
    ack = 1'b0;
    step(2);
    check("R7 ready low before ack low seen", rx_ready, 0);
    step(1);
    check("R7 ready up", rx_ready, 1);
    check("R7 locked with selects", {set_lock_ref, set_lock_data, 3'(seq_state)}, 5'b11_101);
    check("R10 busy low when locked", seq_busy, 0);
    pulse_start();
    lock_ref = 1'b1;
    step(3);
    check("R10 start ignored when locked", seq_state, 5);

    // Glitch sweep over every offset inside the stability window
    for (int g = 1; g < REF; g++) begin
      do_reset();
      pulse_start();
      ack = 1'b1;
      step(3);
      lock_ref = 1'b1;
      step(g);
      lock_ref = 1'b0;
      step(1);
      lock_ref = 1'b1;
      step(REF + 1);
      check($sformatf("R4 glitch at %0d restarts window", g), set_lock_data, 0);
      step(1);
      check($sformatf("R4 glitch at %0d full window then set", g), set_lock_data, 1);
    end

    // Scenario B: calibration busy, timeout on assert ack, recovery
    do_reset();
    cal_busy = 1'b1;
    step(3);
    pulse_start();
    step(1);
    check("R2 start blocked by cal busy", seq_state, 0);
    cal_busy = 1'b0;
    step(3);
    pulse_start();
    step(ACK_TO - 1);
    check("R8 no error before timeout", {seq_error, 3'(seq_state)}, 4'b0_001);
    step(1);
    check("R8 error after assert timeout", {seq_error, rx_dreset, rx_ready, 3'(seq_state)}, 6'b110_110);
    pulse_start();
    check("R9 restart from error", {seq_error, set_lock_data, rx_dreset, 3'(seq_state)}, 6'b001_001);

    // Scenario C: timeout on release wait (ack stuck high, lock_data low)
    ack = 1'b1;
    lock_data = 1'b0;
    step(3);
    check("R3 state 2 after recovery", seq_state, 2);
    lock_ref = 1'b1;
    step(REF + 2);
    check("R4 lockdata after recovery", set_lock_data, 1);
    step(DWELL);
    check("R6 state 4 after dwell", seq_state, 4);
    step(ACK_TO - 1);
    check("R7 no ready while ack high", {rx_ready, 3'(seq_state)}, 4'b0_100);
    step(1);
    check("R8 error after release timeout", {seq_error, rx_dreset, set_lock_data, 3'(seq_state)}, 6'b111_110);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule